// File: doc/BRIEF.md
# Receive Address Filter and Descriptor Ring Writer

This block decides whether an incoming Ethernet frame is kept and, when it is, books it into a ring of receive descriptors held in system memory. A frame is presented as a destination address and a length. The keep decision has three parts. There is a length ceiling. Broadcast and multicast frames each have a drop enable and a don't-care override. Every other destination must match the 48-bit station address exactly. Frames that fail the decision are consumed silently.

A kept frame reads the three words of the current descriptor: the buffer address, the size/flag word and the next pointer. If the size word marks the descriptor as free, the payload transfer is abstracted to a request/done handshake that carries the buffer address and length. The size word is then rewritten with the length, the received-packet count is bumped, and the ring pointer follows the next pointer. If the descriptor is still owned by software, the receive DMA enable is dropped and an overflow flag is raised. The ring does not stall in that case. Software sees the state through a small word-indexed register file. A level interrupt combines a mask with the status bits.

Top module: `rx_filter_dma`

## Requirements
- R1: After reset the length ceiling register (index 3) reads 0x600, the don't-care register (index 5) reads 0x3FFFF, the receive status (index 8), the receive DMA control (index 6) and the interrupt register (index 10) read 0, and `irq` is low.
- R2: A frame whose length exceeds bits [15:0] of register 3 is consumed without any change to the descriptors or the status. A frame of exactly that length is kept.
- R3: An all-ones destination is broadcast. It is kept unless bit 9 of register 5 is 0 and bit 9 of register 4 is 1. The multicast bits have no effect on it.
- R4: A non-broadcast destination whose first octet (`frm_dst[47:40]`) has bit 0 set is multicast. It is kept unless bit 8 of register 5 is 0 and bit 8 of register 4 is 1. The broadcast bits have no effect on it.
- R5: Any other destination is kept only when all six octets equal the station address. Register 1 holds octets 1 to 4, with octet 1 in bits [31:24]. Bits [31:16] of register 2 hold octets 5 and 6.
- R6: A kept frame reads the descriptor words at pointer+0 (buffer), +4 (size) and +8 (next). When bit 31 of the size word is set, the block requests the payload at the buffer address. It then writes the size word as the length masked to 11 bits, with bit 31 clear. The count in status bits [23:16] increments, status bit 0 is set, and the pointer moves to the next word.
- R7: A kept frame whose size word has bit 31 clear is consumed. The block clears bit 0 of register 6, sets status bit 2, writes nothing, and leaves the count and the pointer unchanged.
- R8: Writing 1 to status bit 2 clears the overflow flag. Writing 1 to status bit 0 decrements the count, and bit 0 clears when the count reaches 0.
- R9: A frame is taken only while bit 2 of register 0 and bit 0 of register 6 are both set. Otherwise `frm_ready` stays low.
- R10: Writing register 6 with bit 0 set reloads the ring pointer from register 7. Bits [1:0] of register 7 always read 0.
- R11: Register 10 reads the mask (register 9) ANDed with {status[3:0], 4'b0000}. `irq` is high exactly when that value is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| frm_valid | input | 1 | A frame is presented; held until `frm_ready` |
| frm_dst | input | 48 | Destination address, first octet in [47:40] |
| frm_len | input | 16 | Frame length in bytes |
| frm_ready | output | 1 | Frame consumed this cycle (kept, dropped or overflowed) |
| mem_req | output | 1 | Descriptor memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| pay_req | output | 1 | Payload transfer request |
| pay_addr | output | 32 | Buffer address of the payload |
| pay_len | output | 11 | Payload length |
| pay_done | input | 1 | Payload transfer complete |
| irq | output | 1 | Level interrupt |

## Verification
A stale ring pointer shows up in the descriptor written by the very next kept frame: its size word lands in the wrong slot, and `pay_addr` names the wrong buffer. A wrong filter decision shows up in the packet count read right after the frame completes. A missed overflow leaves bit 0 of register 6 set, so the following frame is still taken. A count that drifts from its flag is exposed when software drains the count one step at a time. The flag must still be set before the final decrement and clear just after it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [2:0] {
      E_IDLE, E_RD_BUF, E_RD_SIZE, E_RD_NEXT, E_PAY, E_WR_SIZE, E_DONE
   } eng_state_t;

   localparam logic [3:0] IDX_MAC    = 4'd0;
   localparam logic [3:0] IDX_STA_HI = 4'd1;
   localparam logic [3:0] IDX_STA_LO = 4'd2;
   localparam logic [3:0] IDX_MAXLEN = 4'd3;
   localparam logic [3:0] IDX_DROP   = 4'd4;
   localparam logic [3:0] IDX_DC     = 4'd5;
   localparam logic [3:0] IDX_RXCTL  = 4'd6;
   localparam logic [3:0] IDX_BASE   = 4'd7;
   localparam logic [3:0] IDX_STAT   = 4'd8;
   localparam logic [3:0] IDX_MASK   = 4'd9;
   localparam logic [3:0] IDX_IRQ    = 4'd10;

   localparam int RX_EN_BIT  = 2;
   localparam int DMA_EN_BIT = 0;
   localparam int BC_BIT     = 9;
   localparam int MC_BIT     = 8;
   localparam int ST_RCVD    = 0;
   localparam int ST_OVF     = 2;
   localparam int ST_CNT_LSB = 16;
   localparam int FREE_BIT   = 31;

   localparam logic [31:0] MAXLEN_RST = 32'h0000_0600;
   localparam logic [31:0] DC_RST     = 32'h0003_FFFF;

endpackage

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter #(
   parameter int LEN_W = 16,
   parameter int OCTETS = 6
) (
   input  logic [8*OCTETS-1:0] dst,
   input  logic [LEN_W-1:0]    len,
   input  logic [8*OCTETS-1:0] station,
   input  logic [LEN_W-1:0]    len_max,
   input  logic                bc_drop,
   input  logic                bc_dc,
   input  logic                mc_drop,
   input  logic                mc_dc,
   output logic                keep
);
   localparam int AW = 8 * OCTETS;

   logic [OCTETS-1:0] oct_eq;
   logic is_bc, is_mc, bc_ok, mc_ok, addr_ok;

   for (genvar i = 0; i < OCTETS; i++) begin : g_oct
      assign oct_eq[i] = (dst[8*i +: 8] == station[8*i +: 8]);
   end

   assign is_bc = &dst;
   assign is_mc = dst[AW-8];
   // don't-care outranks drop
   assign bc_ok = bc_dc | ~bc_drop;
   assign mc_ok = mc_dc | ~mc_drop;

   always_comb begin
      if (is_bc)      addr_ok = bc_ok;
      else if (is_mc) addr_ok = mc_ok;
      else            addr_ok = &oct_eq;
   end

   assign keep = (len <= len_max) && addr_ok;
endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
   import rxf_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        idx,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              ovf_set,
   input  logic              dma_stop,
   input  logic              pkt_inc,
   output logic              rx_on,
   output logic              dma_start,
   output logic [31:0]       base,
   output logic [47:0]       station,
   output logic [LEN_W-1:0]  len_max,
   output logic              bc_drop,
   output logic              bc_dc,
   output logic              mc_drop,
   output logic              mc_dc,
   output logic              irq
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("rxf_regs: CNT_W must be 1..16");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("rxf_regs: LEN_W must be 1..16");
   end

   logic [31:0] mac_r, sta_hi_r, sta_lo_r, maxlen_r, drop_r, dc_r, rxctl_r, base_r, mask_r;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic ovf, rcvd;
   logic [31:0] st_word;
   logic [7:0]  irq_vec;
   logic        dec, clr_ovf;

   assign dec     = wr_en && (idx == IDX_STAT) && wdata[ST_RCVD];
   assign clr_ovf = wr_en && (idx == IDX_STAT) && wdata[ST_OVF];
   assign cnt_n   = cnt + CNT_W'(pkt_inc) - CNT_W'(dec);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mac_r    <= '0;
         sta_hi_r <= '0;
         sta_lo_r <= '0;
         maxlen_r <= MAXLEN_RST;
         drop_r   <= '0;
         dc_r     <= DC_RST;
         rxctl_r  <= '0;
         base_r   <= '0;
         mask_r   <= '0;
         cnt      <= '0;
         ovf      <= 1'b0;
         rcvd     <= 1'b0;
      end else begin
         if (wr_en) begin
            case (idx)
               IDX_MAC:    mac_r    <= wdata;
               IDX_STA_HI: sta_hi_r <= wdata;
               IDX_STA_LO: sta_lo_r <= wdata;
               IDX_MAXLEN: maxlen_r <= wdata;
               IDX_DROP:   drop_r   <= wdata;
               IDX_DC:     dc_r     <= wdata;
               IDX_BASE:   base_r   <= {wdata[31:2], 2'b00};
               IDX_MASK:   mask_r   <= wdata;
               default: ;
            endcase
         end
         if (wr_en && idx == IDX_RXCTL) rxctl_r <= wdata;
         else if (dma_stop)             rxctl_r[DMA_EN_BIT] <= 1'b0;

         cnt <= cnt_n;
         if (pkt_inc)                    rcvd <= 1'b1;
         else if (dec && cnt_n == '0)    rcvd <= 1'b0;
         if (ovf_set)      ovf <= 1'b1;
         else if (clr_ovf) ovf <= 1'b0;
      end
   end

   always_comb begin
      st_word = '0;
      st_word[ST_CNT_LSB +: CNT_W] = cnt;
      st_word[ST_OVF]  = ovf;
      st_word[ST_RCVD] = rcvd;
   end

   assign irq_vec = mask_r[7:0] & {st_word[3:0], 4'b0000};
   assign irq     = |irq_vec;

   always_comb begin
      case (idx)
         IDX_MAC:    rdata = mac_r;
         IDX_STA_HI: rdata = sta_hi_r;
         IDX_STA_LO: rdata = sta_lo_r;
         IDX_MAXLEN: rdata = maxlen_r;
         IDX_DROP:   rdata = drop_r;
         IDX_DC:     rdata = dc_r;
         IDX_RXCTL:  rdata = rxctl_r;
         IDX_BASE:   rdata = base_r;
         IDX_STAT:   rdata = st_word;
         IDX_MASK:   rdata = mask_r;
         IDX_IRQ:    rdata = {24'b0, irq_vec};
         default:    rdata = '0;
      endcase
   end

   assign rx_on     = mac_r[RX_EN_BIT] && rxctl_r[DMA_EN_BIT];
   assign dma_start = wr_en && (idx == IDX_RXCTL) && wdata[DMA_EN_BIT];
   assign base      = base_r;
   assign station   = {sta_hi_r, sta_lo_r[31:16]};
   assign len_max   = maxlen_r[LEN_W-1:0];
   assign bc_drop   = drop_r[BC_BIT];
   assign mc_drop   = drop_r[MC_BIT];
   assign bc_dc     = dc_r[BC_BIT];
   assign mc_dc     = dc_r[MC_BIT];

   // R7: an overflow event raises the flag and drops the DMA enable
   p_ovf_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_set && !(wr_en && idx == IDX_RXCTL)) |=> (ovf && !rxctl_r[DMA_EN_BIT]));
   // R8: a non-zero count always carries the received flag
   p_cnt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> rcvd);
   // R8: the count moves by at most one per cycle
   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));
   // R11: the interrupt needs a receive-half mask bit
   p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_r[7:4] != 4'b0000));
endmodule

// File: rtl/rxf_desc_engine.sv
module rxf_desc_engine
   import rxf_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int SZ_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_on,
   input  logic             keep,
   input  logic             frm_valid,
   input  logic [LEN_W-1:0] frm_len,
   output logic             frm_ready,
   input  logic             dma_start,
   input  logic [31:0]      base,
   output logic             ovf_set,
   output logic             dma_stop,
   output logic             pkt_inc,
   output logic             mem_req,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_ack,
   output logic             pay_req,
   output logic [31:0]      pay_addr,
   output logic [SZ_W-1:0]  pay_len,
   input  logic             pay_done
);
   if (SZ_W > LEN_W || SZ_W >= FREE_BIT) begin : g_bad_sz
      $error("rxf_desc_engine: SZ_W must not exceed LEN_W and must stay below the free flag");
   end

   eng_state_t state;
   logic [31:0] cur, buf_q, nxt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= E_IDLE;
         cur   <= '0;
         buf_q <= '0;
         nxt_q <= '0;
      end else begin
         if (dma_start)                           cur <= base;
         else if (state == E_WR_SIZE && mem_ack)  cur <= nxt_q;
         case (state)
            E_IDLE:    if (frm_valid && rx_on && keep) state <= E_RD_BUF;
            E_RD_BUF:  if (mem_ack) begin
                          buf_q <= mem_rdata;
                          state <= E_RD_SIZE;
                       end
            E_RD_SIZE: if (mem_ack) state <= mem_rdata[FREE_BIT] ? E_RD_NEXT : E_DONE;
            E_RD_NEXT: if (mem_ack) begin
                          nxt_q <= mem_rdata;
                          state <= E_PAY;
                       end
            E_PAY:     if (pay_done) state <= E_WR_SIZE;
            E_WR_SIZE: if (mem_ack) state <= E_DONE;
            default:   state <= E_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = cur;
      case (state)
         E_RD_SIZE, E_WR_SIZE: mem_addr = cur + 32'd4;
         E_RD_NEXT:            mem_addr = cur + 32'd8;
         default:              mem_addr = cur;
      endcase
      mem_wdata = '0;
      mem_wdata[SZ_W-1:0] = frm_len[SZ_W-1:0];
   end

   assign mem_req   = (state == E_RD_BUF) || (state == E_RD_SIZE) ||
                      (state == E_RD_NEXT) || (state == E_WR_SIZE);
   assign mem_we    = (state == E_WR_SIZE);
   assign ovf_set   = (state == E_RD_SIZE) && mem_ack && !mem_rdata[FREE_BIT];
   assign dma_stop  = ovf_set;
   assign pkt_inc   = (state == E_WR_SIZE) && mem_ack;
   assign pay_req   = (state == E_PAY);
   assign pay_addr  = buf_q;
   assign pay_len   = frm_len[SZ_W-1:0];
   assign frm_ready = ((state == E_IDLE) && frm_valid && rx_on && !keep) || (state == E_DONE);

   // R10: enabling the DMA reloads the ring pointer from the base
   p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |=> (cur == $past(base)));
   // R9: a frame is only consumed while one is offered
   p_ready_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ready |-> frm_valid);
   // R9: with reception off the engine never leaves idle
   p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == E_IDLE && !rx_on) |=> (state == E_IDLE));
   // R7: a busy descriptor ends the frame without any write
   p_ovf_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> (state == E_DONE && !mem_req));
endmodule

// File: rtl/rx_filter_dma.sv
module rx_filter_dma
   import rxf_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LEN_W = 16,
   parameter int SZ_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [3:0]       reg_idx,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             frm_valid,
   input  logic [47:0]      frm_dst,
   input  logic [LEN_W-1:0] frm_len,
   output logic             frm_ready,
   output logic             mem_req,
   output logic             mem_we,
   output logic [31:0]      mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_ack,
   output logic             pay_req,
   output logic [31:0]      pay_addr,
   output logic [SZ_W-1:0]  pay_len,
   input  logic             pay_done,
   output logic             irq
);
   logic rx_on, dma_start, ovf_set, dma_stop, pkt_inc, keep;
   logic bc_drop, bc_dc, mc_drop, mc_dc;
   logic [31:0] base;
   logic [47:0] station;
   logic [LEN_W-1:0] len_max;

   rxf_regs #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .idx(reg_idx), .wdata(reg_wdata),
      .rdata(reg_rdata), .ovf_set(ovf_set), .dma_stop(dma_stop), .pkt_inc(pkt_inc),
      .rx_on(rx_on), .dma_start(dma_start), .base(base), .station(station),
      .len_max(len_max), .bc_drop(bc_drop), .bc_dc(bc_dc), .mc_drop(mc_drop),
      .mc_dc(mc_dc), .irq(irq)
   );

   rxf_addr_filter #(.LEN_W(LEN_W), .OCTETS(6)) u_filter (
      .dst(frm_dst), .len(frm_len), .station(station), .len_max(len_max),
      .bc_drop(bc_drop), .bc_dc(bc_dc), .mc_drop(mc_drop), .mc_dc(mc_dc), .keep(keep)
   );

   rxf_desc_engine #(.LEN_W(LEN_W), .SZ_W(SZ_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .keep(keep), .frm_valid(frm_valid),
      .frm_len(frm_len), .frm_ready(frm_ready), .dma_start(dma_start), .base(base),
      .ovf_set(ovf_set), .dma_stop(dma_stop), .pkt_inc(pkt_inc), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .pay_req(pay_req), .pay_addr(pay_addr), .pay_len(pay_len),
      .pay_done(pay_done)
   );

   // R6: every descriptor write hands the slot back with the free flag clear
   p_write_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[FREE_BIT] == 1'b0 && mem_wdata[31:SZ_W] == '0));
endmodule

// File: tb/rx_filter_dma_tb.sv
`timescale 1ns/1ps
module rx_filter_dma_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [3:0] reg_idx = 4'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic frm_valid = 1'b0;
   logic [47:0] frm_dst = '0;
   logic [15:0] frm_len = '0;
   logic frm_ready;
   logic mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic pay_req;
   logic pay_done = 1'b0;
   logic [31:0] pay_addr;
   logic [10:0] pay_len;
   logic irq;

   int n_tests = 0;
   int n_fail = 0;
   int eidx = 0;
   logic [31:0] mem [0:63];
   logic [31:0] pay_seen = '0;

   localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
   localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

   always #2 clk = ~clk;

   rx_filter_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_len(frm_len),
      .frm_ready(frm_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pay_req(pay_req),
      .pay_addr(pay_addr), .pay_len(pay_len), .pay_done(pay_done), .irq(irq)
   );

   assign mem_ack   = mem_req;
   assign mem_rdata = mem[mem_addr[7:2]];

   always @(posedge clk) begin
      if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      pay_done <= pay_req && !pay_done;
      if (pay_req && pay_done) pay_seen <= pay_addr;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = i; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] i, output logic [31:0] d);
      @(negedge clk);
      reg_idx = i;
      #1 d = reg_rdata;
   endtask

   task automatic arm();
      for (int i = 0; i < 4; i++) begin
         mem[i*4]   = 32'h100 + 32'h40 * i;
         mem[i*4+1] = 32'h8000_0000;
         mem[i*4+2] = 32'(16 * ((i + 1) % 4));
      end
   endtask

   task automatic send(input logic [47:0] d, input logic [15:0] l, input int max_wait,
                       output bit taken);
      @(negedge clk);
      frm_dst = d; frm_len = l; frm_valid = 1'b1; taken = 1'b0;
      for (int k = 0; k < max_wait; k++) begin
         if (frm_ready) begin
            taken = 1'b1;
            break;
         end
         @(negedge clk);
      end
      if (taken) @(posedge clk);
      #1 frm_valid = 1'b0;
   endtask

   task automatic frame(input logic [47:0] d, input logic [15:0] l, input bit exp_keep,
                        input string tag);
      logic [31:0] s0, s1;
      bit t;
      arm();
      rd(4'd8, s0);
      send(d, l, 200, t);
      chk({tag, " taken"}, 32'(t), 32'd1);
      rd(4'd8, s1);
      if (exp_keep) begin
         chk({tag, " count+1"}, 32'(s1[23:16]), 32'((s0[23:16] + 8'd1) & 8'hFF));
         chk({tag, " size word"}, mem[eidx*4+1], 32'(l) & 32'h7FF);
         chk({tag, " payload addr"}, pay_seen, 32'h100 + 32'h40 * eidx);
         eidx = (eidx + 1) % 4;
      end else begin
         chk({tag, " count held"}, 32'(s1[23:16]), 32'(s0[23:16]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      bit t;
      arm();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd3, v);  chk("R1 maxlen reset", v, 32'h600);
      rd(4'd5, v);  chk("R1 dontcare reset", v, 32'h3FFFF);
      rd(4'd8, v);  chk("R1 status reset", v, 32'h0);
      rd(4'd6, v);  chk("R1 rxctl reset", v, 32'h0);
      rd(4'd10, v); chk("R1 irq reg reset", v, 32'h0);
      chk("R1 irq pin reset", 32'(irq), 32'd0);

      wr(4'd0, 32'h4);
      wr(4'd1, STA[47:16]);
      wr(4'd2, {STA[15:0], 16'hABCD});
      wr(4'd7, 32'h0000_0003);
      rd(4'd7, v); chk("R10 base low bits", v, 32'h0);
      wr(4'd6, 32'h1);
      eidx = 0;

      // R5 unicast exact match and each octet mismatching
      frame(STA, 16'd64, 1'b1, "R5 match");
      for (int o = 0; o < 6; o++)
         frame(STA ^ (48'h04 << (8 * o)), 16'd64, 1'b0, "R5 octet miss");

      // R3/R4 sweep over all drop/don't-care combinations
      for (int c = 0; c < 16; c++) begin
         bit bdc, bdr, mdc, mdr;
         bdc = c[0]; bdr = c[1]; mdc = c[2]; mdr = c[3];
         wr(4'd4, (32'(bdr) << 9) | (32'(mdr) << 8));
         wr(4'd5, (32'(bdc) << 9) | (32'(mdc) << 8));
         frame(BCAST, 16'd100, bdc | !bdr, "R3 broadcast");
         frame(MCAST, 16'd100, mdc | !mdr, "R4 multicast");
      end
      wr(4'd4, 32'h0);

      // R2 length ceiling
      wr(4'd3, 32'h40);
      frame(STA, 16'h40, 1'b1, "R2 at ceiling");
      frame(STA, 16'h41, 1'b0, "R2 above ceiling");
      wr(4'd3, 32'hFFFF_0040);
      frame(STA, 16'h41, 1'b0, "R2 upper bits ignored");
      wr(4'd3, 32'hFFFF);
      frame(STA, 16'h900, 1'b1, "R6 size masked");

      // R11 interrupt from the received flag
      wr(4'd9, 32'h10);
      #1 chk("R11 irq on rcvd", 32'(irq), 32'd1);
      rd(4'd10, v); chk("R11 irq reg", v, 32'h10);
      wr(4'd9, 32'h0);
      #1 chk("R11 irq masked", 32'(irq), 32'd0);

      // R8 drain the count
      rd(4'd8, v);
      begin
         int n;
         n = int'(v[23:16]);
         for (int k = 0; k < n; k++) begin
            if (k == n - 1) begin
               rd(4'd8, v); chk("R8 flag before last", 32'(v[0]), 32'd1);
            end
            wr(4'd8, 32'h1);
         end
         rd(4'd8, v);
         chk("R8 count drained", 32'(v[23:16]), 32'd0);
         chk("R8 flag cleared", 32'(v[0]), 32'd0);
      end

      // R7 busy descriptor
      arm();
      mem[eidx*4+1] = 32'h0;
      send(STA, 16'd64, 200, t);
      chk("R7 frame consumed", 32'(t), 32'd1);
      rd(4'd8, v);
      chk("R7 overflow set", 32'(v[2]), 32'd1);
      chk("R7 count held", 32'(v[23:16]), 32'd0);
      rd(4'd6, v); chk("R7 dma enable cleared", 32'(v[0]), 32'd0);
      chk("R7 descriptor untouched", mem[eidx*4+1], 32'h0);
      wr(4'd9, 32'h40);
      #1 chk("R11 irq on overflow", 32'(irq), 32'd1);
      wr(4'd8, 32'h4);
      rd(4'd8, v); chk("R8 overflow w1c", 32'(v[2]), 32'd0);
      chk("R11 irq after clear", 32'(irq), 32'd0);
      wr(4'd9, 32'h0);

      // R9 both enables needed
      send(STA, 16'd64, 20, t);
      chk("R9 dma off not taken", 32'(t), 32'd0);
      wr(4'd0, 32'h0);
      wr(4'd7, 32'h0);
      wr(4'd6, 32'h1);
      eidx = 0;
      send(STA, 16'd64, 20, t);
      chk("R9 mac off not taken", 32'(t), 32'd0);
      wr(4'd0, 32'h4);
      frame(STA, 16'd64, 1'b1, "R9 both on");

      // R10 reload from base
      wr(4'd7, 32'h20);
      wr(4'd6, 32'h1);
      eidx = 2;
      frame(STA, 16'd77, 1'b1, "R10 reload");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule